// File: doc/BRIEF.md
# Data Address Translator

The block turns one 32-bit virtual data address into a physical address for a single load or store. The top address bit picks one of two cases. A privileged access to the upper half falls through an identity window or a window that clears the top three bits. A user access to the upper half may reach only a small store-buffer window, and only when that window is enabled. Every other address either has its top three bits cleared, when translation is off, or is looked up in a fully associative page table. The table entries reach the block as flattened vectors from the table storage that sits next to it.

A lookup first matches entries on page number under the entry's own page size and on the address-space identifier. It then applies the access rights for reads and for writes, and then the first-write (dirty) rule. Each failure has its own fault code. On a fault that comes from the page table, the block records the faulting address and moves its page number into the upper field of the page-table-entry-high register. The lower ten bits of that register, which hold the current identifier, are left as they were. A write to the control register that turns translation on or off emits a one-cycle flush pulse to the translation caches further up.

Results are registered and appear one clock after the request.

Top module: `dat_xlate`

## Requirements
- R1: In privileged mode, an address at or above 0xE000_0000 is passed through unchanged. An address from 0x8000_0000 to 0xBFFF_FFFF is passed through with bits [31:29] cleared.
- R2: In user mode, an address with bit 31 set is passed through unchanged only if it lies in 0xE000_0000..0xE3FF_FFFF and the store-window disable bit is 0. Any other such address gives fault code 1 for a read or 2 for a write.
- R3: When translation is off, any address that R1 and R2 do not handle (bit 31 clear, or privileged 0xC000_0000..0xDFFF_FFFF) comes out with bits [31:29] cleared.
- R4: With translation on, an entry matches only if its valid bit is set and its page number matches under its page mask. Its identifier must also equal PTEH[7:0], unless the entry's share bit is set, or the supervisor-bypass bit is 1 in privileged mode.
- R5: The page size code per entry is 0 = 1 KiB, 1 = 4 KiB, 2 = 64 KiB and 3 = 1 MiB. On success the physical address is (PPN AND mask) OR (virtual address AND NOT mask), where PPN is the entry's physical page base in bits [28:10].
- R6: No matching entry gives code 3 for a read or 4 for a write. Two or more matching entries give code 8, which takes precedence over every rights check.
- R7: A user-mode read of a matched entry whose user flag is clear gives code 5.
- R8: A write needs the writable flag in privileged mode, or both the user and writable flags in user mode; otherwise it gives code 6. A write that passes this check on an entry whose dirty flag is clear gives code 7.
- R9: On codes 3 to 8, TEA takes the request address, and PTEH[31:10] takes address bits [31:10] while PTEH[9:0] keep their value. Codes 0 to 2 leave TEA and PTEH untouched.
- R10: `done` is high exactly in the cycle after a request. `pa_valid` is high only when `done` is high and the code is 0. `pa` is 0 whenever a fault is reported.
- R11: A control write that changes the translate-enable bit raises `flush` for exactly the next cycle. A control write that keeps the bit unchanged does not raise it.
- R12: After reset, `done`, `pa_valid`, `pa`, `fault`, `tea`, `pteh` and `flush` are all 0, and translation, supervisor bypass and store-window disable are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Translate request this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Virtual address |
| priv | input | 1 | Privileged mode |
| ctl_we | input | 1 | Control register write strobe |
| ctl_at | input | 1 | Translate enable value |
| ctl_sv | input | 1 | Supervisor identifier-bypass value |
| ctl_sqmd | input | 1 | User store-window disable value |
| pteh_we | input | 1 | PTEH write strobe |
| pteh_wdata | input | 32 | PTEH write value |
| tlb_valid | input | ENTRIES | Entry valid bits |
| tlb_share | input | ENTRIES | Entry shared (identifier ignored) bits |
| tlb_user | input | ENTRIES | Entry user-access bits |
| tlb_wr | input | ENTRIES | Entry writable bits |
| tlb_dirty | input | ENTRIES | Entry dirty bits |
| tlb_size | input | 2*ENTRIES | Entry page size codes |
| tlb_asid | input | ASID_W*ENTRIES | Entry identifiers |
| tlb_vpn | input | 22*ENTRIES | Entry virtual page bits [31:10] |
| tlb_ppn | input | 19*ENTRIES | Entry physical page bits [28:10] |
| done | output | 1 | Result present |
| pa_valid | output | 1 | Physical address is usable |
| pa | output | 32 | Physical address |
| fault | output | 4 | Fault code, 0 = none |
| tea | output | 32 | Last table-fault address |
| pteh | output | 32 | Page-table-entry-high register |
| flush | output | 1 | Translate-enable change pulse |

## Verification
The hardest case to reach from the ports is a multiple hit. Two entries must overlap under different page masks, or under the share bit, while every other qualifier still allows both to match. The bench reaches it by reloading a small four-entry table between requests. It places a duplicate over a 1 KiB page, turns off the duplicate's valid bit to show that one hit remains, and then re-enables it with a different identifier and the share bit set. The rights and first-write checks are swept over all eight flag combinations, in both modes and for both directions, so their order is pinned down.

// File: rtl/dat_xlate.sv
module dat_xlate #(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_req,
  input  logic                    acc_write,
  input  logic [31:0]             acc_addr,
  input  logic                    priv,
  input  logic                    ctl_we,
  input  logic                    ctl_at,
  input  logic                    ctl_sv,
  input  logic                    ctl_sqmd,
  input  logic                    pteh_we,
  input  logic [31:0]             pteh_wdata,
  input  logic [ENTRIES-1:0]      tlb_valid,
  input  logic [ENTRIES-1:0]      tlb_share,
  input  logic [ENTRIES-1:0]      tlb_user,
  input  logic [ENTRIES-1:0]      tlb_wr,
  input  logic [ENTRIES-1:0]      tlb_dirty,
  input  logic [2*ENTRIES-1:0]    tlb_size,
  input  logic [ASID_W*ENTRIES-1:0] tlb_asid,
  input  logic [22*ENTRIES-1:0]   tlb_vpn,
  input  logic [19*ENTRIES-1:0]   tlb_ppn,
  output logic                    done,
  output logic                    pa_valid,
  output logic [31:0]             pa,
  output logic [3:0]              fault,
  output logic [31:0]             tea,
  output logic [31:0]             pteh,
  output logic                    flush
);
  localparam logic [3:0] F_NONE = 4'd0, F_ADR_RD = 4'd1, F_ADR_WR = 4'd2,
                         F_MISS_RD = 4'd3, F_MISS_WR = 4'd4, F_PROT_RD = 4'd5,
                         F_PROT_WR = 4'd6, F_INIT_WR = 4'd7, F_MULTI = 4'd8;

  logic at_q, sv_q, sqmd_q;

  function automatic logic [31:0] page_mask(input logic [1:0] code);
    case (code)
      2'd0:    page_mask = 32'hFFFF_FC00;
      2'd1:    page_mask = 32'hFFFF_F000;
      2'd2:    page_mask = 32'hFFFF_0000;
      default: page_mask = 32'hFFF0_0000;
    endcase
  endfunction

  wire skip_asid = sv_q & priv;

  logic [ENTRIES-1:0] match;
  logic [31:0] hit_mask, hit_ppn;
  logic hit_user, hit_wr, hit_dirty;

  always_comb begin
    match = '0;
    hit_mask = '0;
    hit_ppn = '0;
    hit_user = 1'b0;
    hit_wr = 1'b0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (tlb_valid[i]
          && (tlb_share[i] || skip_asid || tlb_asid[i*ASID_W +: ASID_W] == pteh[ASID_W-1:0])
          && ((({tlb_vpn[i*22 +: 22], 10'b0} ^ acc_addr) & page_mask(tlb_size[2*i +: 2])) == 32'b0)) begin
        match[i]  = 1'b1;
        hit_mask  = hit_mask | page_mask(tlb_size[2*i +: 2]);
        hit_ppn   = hit_ppn | {3'b0, tlb_ppn[i*19 +: 19], 10'b0};
        hit_user  = hit_user | tlb_user[i];
        hit_wr    = hit_wr | tlb_wr[i];
        hit_dirty = hit_dirty | tlb_dirty[i];
      end
    end
  end

  wire multi = |(match & (match - 1'b1));
  wire [31:0] low29 = {3'b000, acc_addr[28:0]};
  wire [31:0] mapped = (hit_ppn & hit_mask) | (acc_addr & ~hit_mask);

  logic [3:0]  nx_fault;
  logic [31:0] nx_pa;
  logic        lookup;

  always_comb begin
    nx_fault = F_NONE;
    nx_pa = acc_addr;
    lookup = 1'b0;
    if (acc_addr[31]) begin
      if (priv) begin
        if (acc_addr[31:29] == 3'b111) nx_pa = acc_addr;
        else if (acc_addr[31:30] == 2'b10) nx_pa = low29;
        else lookup = 1'b1;
      end else if (acc_addr[31:26] == 6'b111000 && !sqmd_q) begin
        nx_pa = acc_addr;
      end else begin
        nx_fault = acc_write ? F_ADR_WR : F_ADR_RD;
      end
    end else begin
      lookup = 1'b1;
    end
    if (lookup) begin
      if (!at_q) nx_pa = low29;
      else if (match == '0) nx_fault = acc_write ? F_MISS_WR : F_MISS_RD;
      else if (multi) nx_fault = F_MULTI;
      else if (acc_write) begin
        if (priv ? !hit_wr : !(hit_user && hit_wr)) nx_fault = F_PROT_WR;
        else if (!hit_dirty) nx_fault = F_INIT_WR;
        else nx_pa = mapped;
      end else if (!priv && !hit_user) nx_fault = F_PROT_RD;
      else nx_pa = mapped;
    end
  end

  wire table_fault = acc_req && (nx_fault >= F_MISS_RD);
  wire [31:0] pteh_base = pteh_we ? pteh_wdata : pteh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      fault <= F_NONE;
      pa <= '0;
      tea <= '0;
      pteh <= '0;
      at_q <= 1'b0;
      sv_q <= 1'b0;
      sqmd_q <= 1'b0;
      flush <= 1'b0;
    end else begin
      done <= acc_req;
      fault <= acc_req ? nx_fault : F_NONE;
      pa <= (acc_req && nx_fault == F_NONE) ? nx_pa : 32'b0;
      if (table_fault) tea <= acc_addr;
      pteh <= table_fault ? {acc_addr[31:10], pteh_base[9:0]} : pteh_base;
      flush <= ctl_we && (ctl_at != at_q);
      if (ctl_we) begin
        at_q <= ctl_at;
        sv_q <= ctl_sv;
        sqmd_q <= ctl_sqmd;
      end
    end
  end

  assign pa_valid = done && (fault == F_NONE);
endmodule

module dat_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_req,
  input logic [31:0] acc_addr,
  input logic        pteh_we,
  input logic        ctl_we,
  input logic        done,
  input logic        pa_valid,
  input logic [31:0] pa,
  input logic [3:0]  fault,
  input logic [31:0] tea,
  input logic [31:0] pteh,
  input logic        flush
);
  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n) acc_req |=> done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !acc_req |=> !done && fault == 4'd0); // R10
  AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) pa_valid |-> done && fault == 4'd0); // R10
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) fault != 4'd0 |-> pa == 32'd0 && !pa_valid); // R10
  AST_TEA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (done && fault >= 4'd3) |-> tea == $past(acc_addr) && pteh[31:10] == $past(acc_addr[31:10])); // R9
  AST_TEA_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (done && fault inside {4'd1, 4'd2}) |-> $stable(tea)); // R9
  AST_PTEH_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (done && fault >= 4'd3 && !$past(pteh_we)) |-> pteh[9:0] == $past(pteh[9:0])); // R9
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) flush |-> $past(ctl_we)); // R11
endmodule

bind dat_xlate dat_xlate_chk u_chk (.*);

// File: tb/test_dat_xlate.sv
module test_dat_xlate;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_req = 0, acc_write = 0, priv = 0;
  logic [31:0] acc_addr = 0;
  logic ctl_we = 0, ctl_at = 0, ctl_sv = 0, ctl_sqmd = 0, pteh_we = 0;
  logic [31:0] pteh_wdata = 0;
  logic [N-1:0] tlb_valid, tlb_share, tlb_user, tlb_wr, tlb_dirty;
  logic [2*N-1:0] tlb_size;
  logic [8*N-1:0] tlb_asid;
  logic [22*N-1:0] tlb_vpn;
  logic [19*N-1:0] tlb_ppn;
  logic done, pa_valid, flush;
  logic [31:0] pa, tea, pteh;
  logic [3:0] fault;

  logic [31:0] e_base [N], e_ppn [N];
  logic [1:0]  e_size [N];
  logic [7:0]  e_asid [N];
  logic        e_v [N], e_sh [N], e_u [N], e_w [N], e_d [N];
  logic m_at = 0, m_sv = 0, m_sqmd = 0;
  logic [31:0] m_tea = 0, m_pteh = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tlb_valid[i] = e_v[i];
      tlb_share[i] = e_sh[i];
      tlb_user[i] = e_u[i];
      tlb_wr[i] = e_w[i];
      tlb_dirty[i] = e_d[i];
      tlb_size[2*i +: 2] = e_size[i];
      tlb_asid[8*i +: 8] = e_asid[i];
      tlb_vpn[22*i +: 22] = e_base[i][31:10];
      tlb_ppn[19*i +: 19] = e_ppn[i][28:10];
    end
  end

  dat_xlate #(.ENTRIES(N), .ASID_W(8)) i_dat_xlate (.*);

  function automatic logic [31:0] bytes_of(input logic [1:0] s);
    case (s)
      2'd0: bytes_of = 32'd1024;
      2'd1: bytes_of = 32'd4096;
      2'd2: bytes_of = 32'd65536;
      default: bytes_of = 32'd1048576;
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input bit w, input bit p,
                       output logic [3:0] f, output logic [31:0] y);
    int hits = 0, k = 0;
    bit tr = 0;
    logic [31:0] sz;
    f = 0; y = 0;
    if (a >= 32'h8000_0000) begin
      if (p) begin
        if (a >= 32'hE000_0000) y = a;
        else if (a < 32'hC000_0000) y = a % 32'h2000_0000;
        else tr = 1;
      end else if (a >= 32'hE000_0000 && a < 32'hE400_0000 && !m_sqmd) y = a;
      else f = w ? 4'd2 : 4'd1;
    end else tr = 1;
    if (tr) begin
      if (!m_at) y = a % 32'h2000_0000;
      else begin
        for (int i = 0; i < N; i++) begin
          sz = bytes_of(e_size[i]);
          if (e_v[i] && (e_sh[i] || (m_sv && p) || e_asid[i] == m_pteh[7:0]) &&
              a / sz == e_base[i] / sz) begin hits++; k = i; end
        end
        sz = bytes_of(e_size[k]);
        if (hits == 0) f = w ? 4'd4 : 4'd3;
        else if (hits > 1) f = 4'd8;
        else if (w) begin
          if (p ? !e_w[k] : !(e_u[k] && e_w[k])) f = 4'd6;
          else if (!e_d[k]) f = 4'd7;
          else y = (e_ppn[k] / sz) * sz + a % sz;
        end else if (!p && !e_u[k]) f = 4'd5;
        else y = (e_ppn[k] / sz) * sz + a % sz;
      end
    end
    if (f >= 4'd3) begin
      m_tea = a;
      m_pteh = {a[31:10], m_pteh[9:0]};
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic go(input logic [31:0] a, input bit w, input bit p, input string tag);
    logic [3:0] ef;
    logic [31:0] ey;
    model(a, w, p, ef, ey);
    @(negedge clk);
    acc_req = 1; acc_addr = a; acc_write = w; priv = p;
    @(negedge clk);
    acc_req = 0;
    check(done && fault == ef && pa == ey && pa_valid == (ef == 0), tag,
          $sformatf("addr=%h w=%0d p=%0d fault/pa", a, w, p), {fault, pa[27:0]}, {ef, ey[27:0]});
    check(tea == m_tea && pteh == m_pteh, "R9", "tea/pteh", tea ^ pteh, m_tea ^ m_pteh);
  endtask

  task automatic ctl(input bit at, input bit sv, input bit sq);
    bit exp_fl;
    exp_fl = (at != m_at);
    @(negedge clk);
    ctl_we = 1; ctl_at = at; ctl_sv = sv; ctl_sqmd = sq;
    @(negedge clk);
    ctl_we = 0;
    m_at = at; m_sv = sv; m_sqmd = sq;
    check(flush == exp_fl, "R11", "flush pulse", {31'b0, flush}, {31'b0, exp_fl});
    @(negedge clk);
    check(!flush, "R11", "flush width", {31'b0, flush}, 32'd0);
  endtask

  task automatic set_pteh(input logic [31:0] v);
    @(negedge clk);
    pteh_we = 1; pteh_wdata = v;
    @(negedge clk);
    pteh_we = 0;
    m_pteh = v;
  endtask

  task automatic load_table();
    e_base[0] = 32'h0000_1000; e_size[0] = 0; e_asid[0] = 5; e_ppn[0] = 32'h0ABC_D400;
    e_v[0] = 1; e_sh[0] = 0; e_u[0] = 1; e_w[0] = 1; e_d[0] = 1;
    e_base[1] = 32'hC000_0000; e_size[1] = 1; e_asid[1] = 7; e_ppn[1] = 32'h0123_4000;
    e_v[1] = 1; e_sh[1] = 1; e_u[1] = 0; e_w[1] = 1; e_d[1] = 1;
    e_base[2] = 32'h7FFF_0000; e_size[2] = 2; e_asid[2] = 5; e_ppn[2] = 32'h0555_0000;
    e_v[2] = 1; e_sh[2] = 0; e_u[2] = 1; e_w[2] = 0; e_d[2] = 1;
    e_base[3] = 32'h4000_0000; e_size[3] = 3; e_asid[3] = 9; e_ppn[3] = 32'h1230_0000;
    e_v[3] = 1; e_sh[3] = 0; e_u[3] = 1; e_w[3] = 1; e_d[3] = 0;
  endtask

  logic [31:0] addrs [14] = '{32'h0000_1234, 32'h0000_13FC, 32'h0000_1400, 32'h7FFF_FFFC,
                              32'h4001_2345, 32'h8000_0010, 32'hA123_4567, 32'hBFFF_FFFF,
                              32'hC000_0FFF, 32'hDFFF_FFFF, 32'hE000_0000, 32'hE3FF_FFFC,
                              32'hE400_0000, 32'hFFFF_FFFF};

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    load_table();
    repeat (3) @(negedge clk);
    check(!done && !pa_valid && pa == 0 && fault == 0 && tea == 0 && pteh == 0 && !flush,
          "R12", "reset state", {done, pa_valid, flush, fault, tea[24:0]}, 32'd0);
    rst_n = 1;
    go(32'h0000_1234, 0, 0, "R12");
    @(negedge clk);
    check(!done && fault == 0, "R10", "done drops when idle", {28'b0, fault}, 32'd0);
    set_pteh(32'h0000_0305);
    // Region and translation sweep: R1 R2 R3 R4 R5 R6
    for (int c = 0; c < 4; c++) begin
      ctl(c[0], 1'b0, c[1]);
      for (int j = 0; j < 14; j++)
        for (int m = 0; m < 4; m++)
          go(addrs[j], m[0], m[1], "R1/R2/R3/R5/R6");
    end
    // Rights and first-write ordering: R7 R8
    for (int fl = 0; fl < 8; fl++) begin
      e_u[0] = fl[0]; e_w[0] = fl[1]; e_d[0] = fl[2];
      for (int m = 0; m < 4; m++) go(32'h0000_1234, m[0], m[1], "R7/R8");
    end
    load_table();
    // Supervisor bypass: R4
    ctl(1'b1, 1'b1, 1'b0);
    for (int m = 0; m < 4; m++) go(32'h4001_2345, m[0], m[1], "R4");
    go(32'h0000_1234, 0, 1, "R4");
    // Multiple hit and valid gating: R6 R4
    e_base[3] = 32'h0000_1000; e_size[3] = 0; e_asid[3] = 5; e_d[3] = 1;
    go(32'h0000_1234, 0, 0, "R6");
    e_v[3] = 0;
    go(32'h0000_1234, 0, 0, "R4");
    e_v[3] = 1; e_asid[3] = 9; e_sh[3] = 1;
    go(32'h0000_13FF, 1, 0, "R6");
    e_sh[3] = 0;
    go(32'h0000_1234, 1, 0, "R4");
    load_table();
    // PTEH low bits kept, high replaced: R9
    set_pteh(32'hFFFF_FF05);
    go(32'h0000_2000, 0, 0, "R9");
    go(32'hC000_0000, 0, 0, "R2/R9");
    // Control write without AT change: R11
    ctl(1'b1, 1'b0, 1'b1);
    ctl(1'b0, 1'b0, 1'b1);
    ctl(1'b0, 1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule